// File: doc/BRIEF.md
# Predicated Vector Gather Load Sequencer

This block carries out one gather load into a vector register made of 64-bit lanes. A start pulse captures several inputs: a 64-bit scalar base, a vector holding one index value per lane, a per-byte predicate and three mode bits. The block then visits the active lanes one at a time, from the lowest lane upwards. For each active lane it forms an address from the base and that lane's index, issues a single 64-bit read on a valid/ready request channel, and stores the returned doubleword unchanged in that lane.

Inactive lanes never reach memory and read back as zero. When every active lane has been filled, a one-cycle done pulse marks the result vector as complete. The result then holds its value until the next accepted start.

The block is meant to sit between a vector execution pipeline and a load port that allows one outstanding read at a time. Decoding, fault handling, alignment traps, caching and tag checks belong elsewhere.

Top module: `gather_seq`

## Requirements
- R1: Each read address equals the 64-bit base plus the lane offset; when `idx_scaled` is 1 the offset is first shifted left by 3 (multiplied by 8), and when it is 0 the offset is used as is.
- R2: When `idx_wide` is 0 and `idx_signed` is 0, the offset is the low 32 bits of the lane index, zero-extended to 64 bits; bits 63:32 of the index have no effect.
- R3: When `idx_wide` is 0 and `idx_signed` is 1, the offset is the low 32 bits of the lane index, sign-extended from bit 31.
- R4: When `idx_wide` is 1, the full 64-bit lane index is the offset, with no extension, whatever the value of `idx_signed`.
- R5: A lane whose predicate bit is 0 issues no read, and its 64 bits of `result` are all zero.
- R6: Lane e is active exactly when `pred[e*8]` is 1; all other predicate bits are ignored. Lane e occupies `result[e*64 +: 64]` and `index_vec[e*64 +: 64]`.
- R7: Reads are issued in strictly ascending lane order with at most one outstanding. No new request appears until the response to the previous one has been taken.
- R8: When no lane is active, `done` is high in the cycle after start, `result` is all zero, and no request is issued.
- R9: `start` is ignored while an operation is in progress.
- R10: After reset, `done`, `req_valid` and `result` are zero. `done` lasts exactly one cycle, and `result` stays stable from done until the next accepted start.
- R11: Once `req_valid` is raised it stays high with a stable `req_addr` until `req_ready` is seen.
- R12: The address sum wraps modulo 2^64, and the carry out is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a gather; sampled only when idle |
| base | input | 64 | Scalar base address |
| index_vec | input | VLEN | Per-lane index values, 64 bits per lane |
| pred | input | VLEN/8 | Predicate, one bit per byte of vector |
| idx_wide | input | 1 | 1: 64-bit index, 0: 32-bit index |
| idx_signed | input | 1 | 32-bit mode only: 1 sign-extend, 0 zero-extend |
| idx_scaled | input | 1 | 1: offset times 8, 0: offset times 1 |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Read request address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 64 | Returned doubleword |
| done | output | 1 | One-cycle completion pulse |
| result | output | VLEN | Gathered vector |

## Verification
The bench builds the block with the default VLEN of 256, which gives four lanes and a 32-bit predicate. With four lanes it can fill every lane, leave none active, and make gaps in the lane order, and it can still check each lane, each address and each request's position by hand. The predicate patterns set the bits between multiples of 8, so a lane decoded from the wrong bit becomes visible. The memory model varies its ready stalls and its response latency, so the request-hold and single-outstanding rules are exercised under back-pressure.

// File: rtl/gather_pkg.sv
package gather_pkg;

  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_ISSUE = 2'd1,
    GS_WAIT  = 2'd2
  } gs_state_t;

  // Offset processing followed by the modulo-2^64 address sum.
  function automatic logic [63:0] form_addr(
    input logic [63:0] base,
    input logic [63:0] idx,
    input logic        wide,
    input logic        sgn,
    input logic        scl
  );
    logic [63:0] off;
    if (wide)
      off = idx;
    else if (sgn)
      off = {{32{idx[31]}}, idx[31:0]};
    else
      off = {32'd0, idx[31:0]};
    if (scl)
      off = {off[60:0], 3'b000};
    return base + off;
  endfunction

endpackage

// File: rtl/gather_lane_pick.sv
module gather_lane_pick #(
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] mask,
  output logic [LW-1:0]    lane,
  output logic             any
);
  always_comb begin
    lane = '0;
    any  = |mask;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) lane = i[LW-1:0];
    end
  end
endmodule

// File: rtl/gather_addr_unit.sv
module gather_addr_unit #(
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [63:0]         base,
  input  logic [LANES*64-1:0] idx_vec,
  input  logic [LW-1:0]       lane,
  input  logic                wide,
  input  logic                sgn,
  input  logic                scl,
  output logic [63:0]         addr
);
  import gather_pkg::*;
  logic [63:0] lane_idx;
  always_comb begin
    lane_idx = idx_vec[lane*64 +: 64];
    addr     = form_addr(base, lane_idx, wide, sgn, scl);
  end
endmodule

// File: rtl/gather_seq.sv
module gather_seq #(
  parameter int VLEN = 256,
  localparam int LANES = VLEN / 64,
  localparam int PBITS = VLEN / 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      base,
  input  logic [VLEN-1:0]  index_vec,
  input  logic [PBITS-1:0] pred,
  input  logic             idx_wide,
  input  logic             idx_signed,
  input  logic             idx_scaled,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [63:0]      req_addr,
  input  logic             rsp_valid,
  input  logic [63:0]      rsp_data,
  output logic             done,
  output logic [VLEN-1:0]  result
);
  import gather_pkg::*;

  gs_state_t        state_q;
  logic [63:0]      base_q;
  logic [VLEN-1:0]  idx_q;
  logic             wide_q, sgn_q, scl_q;
  logic [LANES-1:0] pend_q;
  logic [LANES-1:0] act_in;
  logic [LW-1:0]    cur_lane;
  logic             pend_any;
  logic             done_q;
  logic [VLEN-1:0]  result_q;

  // Named events for the assertions.
  logic busy, accept, req_fire, rsp_fire, last_rsp;

  genvar e;
  generate
    for (e = 0; e < LANES; e++) begin : g_act
      assign act_in[e] = pred[e*8];
    end
  endgenerate

  gather_lane_pick #(.LANES(LANES)) u_pick (
    .mask (pend_q),
    .lane (cur_lane),
    .any  (pend_any)
  );

  gather_addr_unit #(.LANES(LANES)) u_addr (
    .base    (base_q),
    .idx_vec (idx_q),
    .lane    (cur_lane),
    .wide    (wide_q),
    .sgn     (sgn_q),
    .scl     (scl_q),
    .addr    (req_addr)
  );

  assign busy      = (state_q != GS_IDLE);
  assign accept    = start && !busy;
  assign req_valid = (state_q == GS_ISSUE);
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = (state_q == GS_WAIT) && rsp_valid;
  assign last_rsp  = rsp_fire && ((pend_q & ~(LANES'(1) << cur_lane)) == '0);
  assign done      = done_q;
  assign result    = result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= GS_IDLE;
      base_q   <= '0;
      idx_q    <= '0;
      wide_q   <= 1'b0;
      sgn_q    <= 1'b0;
      scl_q    <= 1'b0;
      pend_q   <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        GS_IDLE: begin
          if (accept) begin
            base_q   <= base;
            idx_q    <= index_vec;
            wide_q   <= idx_wide;
            sgn_q    <= idx_signed;
            scl_q    <= idx_scaled;
            pend_q   <= act_in;
            result_q <= '0;
            if (|act_in) state_q <= GS_ISSUE;
            else         done_q  <= 1'b1;
          end
        end
        GS_ISSUE: begin
          if (req_fire) state_q <= GS_WAIT;
        end
        GS_WAIT: begin
          if (rsp_fire) begin
            result_q[cur_lane*64 +: 64] <= rsp_data;
            pend_q[cur_lane]            <= 1'b0;
            if (last_rsp) begin
              state_q <= GS_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= GS_ISSUE;
            end
          end
        end
        default: state_q <= GS_IDLE;
      endcase
    end
  end

  // R11: request held with stable address until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R7: after a handshake no request until the response arrives
  p_one_outst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid);

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: result stable while idle without an accepted start
  p_result_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

  // R8: empty predicate finishes next cycle with no request
  p_empty_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(|act_in)) |=> (done && !req_valid && (result == '0)));

  // R5: a response never targets a lane that was not pending
  p_pend_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |-> pend_any);

endmodule

// File: tb/gather_seq_tb.sv
module gather_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN  = 256;
  localparam int LANES = VLEN / 64;
  localparam int PBITS = VLEN / 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [63:0]      base = '0;
  logic [VLEN-1:0]  index_vec = '0;
  logic [PBITS-1:0] pred = '0;
  logic             idx_wide = 1'b0, idx_signed = 1'b0, idx_scaled = 1'b0;
  logic             req_valid, req_ready;
  logic [63:0]      req_addr;
  logic             rsp_valid;
  logic [63:0]      rsp_data;
  logic             done;
  logic [VLEN-1:0]  result;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gather_seq #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base),
    .index_vec(index_vec), .pred(pred), .idx_wide(idx_wide),
    .idx_signed(idx_signed), .idx_scaled(idx_scaled),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .result(result)
  );

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return {a[31:0], a[63:32]} ^ 64'hC3A5_0F1E_7B2D_9684;
  endfunction

  // Memory model: ready stalls and response latency vary with stall_mode.
  int          stall_mode = 0;
  int          cyc = 0;
  logic        m_pend = 1'b0;
  int          m_dly = 0;
  logic [63:0] m_addr = '0;
  logic [63:0] req_log [0:15];
  int          n_req = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (req_valid && req_ready) begin
      if (n_req < 16) req_log[n_req] <= req_addr;
      n_req  <= n_req + 1;
      m_pend <= 1'b1;
      m_addr <= req_addr;
      m_dly  <= (stall_mode == 0) ? 0 : (cyc % 3);
    end else if (rsp_valid) begin
      m_pend <= 1'b0;
    end else if (m_pend && m_dly != 0) begin
      m_dly <= m_dly - 1;
    end
  end

  always @(negedge clk) begin
    req_ready <= (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    rsp_valid <= m_pend && (m_dly == 0);
    rsp_data  <= mem_word(m_addr);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_addr(input logic [63:0] b, input logic [63:0] idx,
                                           input logic w, input logic s, input logic sc);
    logic signed [63:0] so;
    logic [63:0] off;
    so  = $signed(idx[31:0]);
    off = w ? idx : (s ? so : {32'd0, idx[31:0]});
    if (sc) off = off * 64'd8;
    return b + off;
  endfunction

  // Run one gather and compare addresses, order and lanes against the model.
  task automatic run_gather(input string req, input logic [63:0] b, input logic [VLEN-1:0] iv,
                            input logic [PBITS-1:0] p, input logic w, input logic s,
                            input logic sc);
    int exp_n = 0;
    int t = 0;
    logic [63:0] ea [0:LANES-1];
    logic [VLEN-1:0] er = '0;
    @(negedge clk);
    n_req = 0;
    base = b; index_vec = iv; pred = p;
    idx_wide = w; idx_signed = s; idx_scaled = sc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base = ~b; index_vec = ~iv;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(done, req, "done seen", {255'd0, done}, 256'd1);
    for (int l = 0; l < LANES; l++) begin
      if (p[l*8]) begin
        ea[exp_n] = exp_addr(b, iv[l*64 +: 64], w, s, sc);
        er[l*64 +: 64] = mem_word(ea[exp_n]);
        exp_n++;
      end
    end
    check(n_req == exp_n, req, "request count", 256'(n_req), 256'(exp_n));
    for (int k = 0; k < exp_n; k++)
      check(req_log[k] == ea[k], req, $sformatf("address of request %0d", k),
            256'(req_log[k]), 256'(ea[k]));
    check(result == er, req, "result vector", result, er);
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R10", "reset done", 256'(done), 256'd0);
    check(req_valid == 1'b0, "R10", "reset req_valid", 256'(req_valid), 256'd0);
    check(result == '0, "R10", "reset result", result, 256'd0);
  endtask

  task automatic t_wide_scaled();
    // R1 R4 R7: all lanes active, 64-bit index with top bits set, times 8
    stall_mode = 1;
    run_gather("R1/R4/R7", 64'h0000_1000_0000_0000,
               {64'h0000_0000_0000_0040, 64'h0000_0001_0000_0003,
                64'h8000_0000_0000_0010, 64'h0000_0000_0000_0001},
               32'h0101_0101, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_zero_ext();
    // R2: garbage in bits 63:32, bit 31 set, zero-extend, unscaled
    stall_mode = 0;
    run_gather("R2", 64'h0000_0000_4000_0000,
               {64'hDEAD_BEEF_8000_0004, 64'h1234_5678_0000_0100,
                64'hFFFF_FFFF_FFFF_FFF8, 64'hAAAA_5555_0000_0008},
               32'h0101_0101, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sign_ext();
    // R3: negative 32-bit indices, scaled
    stall_mode = 1;
    run_gather("R3", 64'h0000_0000_0010_0000,
               {64'h0000_0000_FFFF_FFFF, 64'h7777_7777_8000_0000,
                64'h0000_0000_0000_0010, 64'h0000_0000_FFFF_FFF0},
               32'h0101_0101, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_wide_ignores_sign();
    // R4: wide mode ignores idx_signed
    stall_mode = 0;
    run_gather("R4", 64'h0000_0000_0000_1000,
               {64'h0000_0000_8000_0000, 64'h0, 64'h0, 64'h0000_0000_FFFF_0000},
               32'h0100_0001, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_sparse_pred();
    // R5 R6: lanes 1 and 3 active; bits off multiples of 8 set for lanes 0 and 2
    stall_mode = 1;
    run_gather("R5/R6", 64'h0000_0000_0000_8000,
               {64'h30, 64'h20, 64'h10, 64'h08},
               32'h01FE_01FE, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_empty();
    // R8: no active lane, only non-lane bits set
    @(negedge clk);
    n_req = 0;
    pred = 32'hFEFE_FEFE; base = 64'h55; index_vec = '1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R8", "done one cycle after start", 256'(done), 256'd1);
    check(result == '0, "R8", "empty result", result, 256'd0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done single pulse", 256'(done), 256'd0);
    repeat (3) @(negedge clk);
    check(n_req == 0, "R8", "no request", 256'(n_req), 256'd0);
  endtask

  task automatic t_wrap();
    // R12: sum passes 2^64
    stall_mode = 0;
    run_gather("R12", 64'hFFFF_FFFF_FFFF_FFF0,
               {64'h0, 64'h0, 64'h0000_0000_0000_0004, 64'h0000_0000_0000_0020},
               32'h0000_0101, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_start_busy();
    // R9: second start during the operation is ignored
    logic [VLEN-1:0] first;
    int t = 0;
    stall_mode = 1;
    @(negedge clk);
    n_req = 0;
    base = 64'h2000; index_vec = {64'h3, 64'h2, 64'h1, 64'h0}; pred = 32'h0101_0101;
    idx_wide = 1'b1; idx_signed = 1'b0; idx_scaled = 1'b1;
    start = 1'b1;
    @(negedge clk);
    base = 64'h9999_0000; pred = 32'h0000_0001;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    first = {mem_word(64'h2018), mem_word(64'h2010), mem_word(64'h2008), mem_word(64'h2000)};
    check(result == first, "R9", "result of first op", result, first);
    repeat (4) @(negedge clk);
    check(n_req == 4, "R9", "request count", 256'(n_req), 256'd4);
  endtask

  task automatic t_hold();
    // R10: result stable after done while inputs change
    logic [VLEN-1:0] snap;
    snap = result;
    @(negedge clk);
    base = 64'h1; index_vec = '1; pred = '1;
    repeat (5) @(negedge clk);
    check(result == snap, "R10", "result held", result, snap);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_wide_scaled();
    t_hold();
    t_zero_ext();
    t_sign_ext();
    t_wide_ignores_sign();
    t_sparse_pred();
    t_empty();
    t_wrap();
    t_start_busy();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule